// File: doc/BRIEF.md
# Bridge Forwarding Window Decoder

This block decides whether a transaction address seen on the upstream side of a bus bridge belongs to the bridge's secondary side. The bridge's configuration fields come in as a live snapshot. These are the packed I/O, memory and prefetchable base/limit fields, the upper extension words, the two command enables and the legacy-display enable. From them the block rebuilds three address windows. Each window is rebuilt by removing the type nibble from the packed field, placing the remaining bits at their address position and filling the low bits of the limit with ones.

A request is an address, a space flag (I/O or memory) and a one-cycle strobe. One clock after the strobe, the block reports whether the address is claimed and which window claimed it. The decoded base and limit of every window are always visible as combinational outputs, so the surrounding bridge logic can use them for diagnostics or for forwarding decisions.

Top module: `bridge_window_decoder`

## Requirements
- R1: While reset is asserted and after it is released, `hit_valid`, `hit` and `hit_win` are all zero until the first strobe.
- R2: A strobe on `req_valid` at a clock edge produces `hit_valid`=1 after that edge, with `hit` and `hit_win` computed from the inputs sampled at that edge. With no strobe, `hit_valid` is 0 after the edge.
- R3: The I/O window base is `cfg_io_base[7:4]` at address bits 15:12, with bits 11:0 zero. When bit 0 of `cfg_io_base` is 1 (32-bit I/O type), `cfg_io_base_hi` supplies bits 31:16; otherwise those bits are zero. The I/O limit is decoded the same way from `cfg_io_limit` and `cfg_io_limit_hi`, and its bits 11:0 are all ones.
- R4: The memory window base is `{cfg_mem_base[15:4], 20'h0}` zero-extended to 64 bits. The memory limit is decoded the same way from `cfg_mem_limit`, with bits 19:0 all ones.
- R5: The prefetchable window is decoded like the memory window. When bit 0 of `cfg_pf_base` (or of `cfg_pf_limit`) is 1 (64-bit type), `cfg_pf_base_hi` (or `cfg_pf_limit_hi`) supplies bits 63:32; otherwise those bits are zero.
- R6: Memory requests, including legacy display memory, can hit only while `cfg_mem_en` is 1. I/O requests, including legacy display I/O, can hit only while `cfg_io_en` is 1.
- R7: A window whose decoded limit is below its decoded base never hits.
- R8: While `cfg_vga_en` is 1, I/O addresses whose bits 15:0 lie in 0x3B0..0x3BB or 0x3C0..0x3DF hit, and memory addresses in 0xA0000..0xBFFFF hit, whatever the base/limit windows hold.
- R9: Window codes are 0 for I/O, 1 for memory, 2 for prefetchable and 3 for legacy display. For a memory request, priority runs prefetchable, then memory, then legacy display. For an I/O request, the I/O window takes priority over legacy display. An I/O request never reports code 1 or 2.
- R10: An I/O window hit compares address bits 31:0 only. Memory hits use a full 64-bit unsigned base <= addr <= limit comparison.
- R11: When a strobed request misses, or when there was no strobe, `hit` is 0 and `hit_win` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_is_io | input | 1 | 1 for the I/O space, 0 for memory |
| req_addr | input | 64 | Request address |
| cfg_io_base | input | 8 | Packed I/O base byte (type in bits 3:0) |
| cfg_io_limit | input | 8 | Packed I/O limit byte |
| cfg_io_base_hi | input | 16 | I/O base address bits 31:16 |
| cfg_io_limit_hi | input | 16 | I/O limit address bits 31:16 |
| cfg_mem_base | input | 16 | Packed memory base word |
| cfg_mem_limit | input | 16 | Packed memory limit word |
| cfg_pf_base | input | 16 | Packed prefetchable base word (type in bits 3:0) |
| cfg_pf_limit | input | 16 | Packed prefetchable limit word |
| cfg_pf_base_hi | input | 32 | Prefetchable base bits 63:32 |
| cfg_pf_limit_hi | input | 32 | Prefetchable limit bits 63:32 |
| cfg_io_en | input | 1 | Command I/O enable |
| cfg_mem_en | input | 1 | Command memory enable |
| cfg_vga_en | input | 1 | Legacy display forwarding enable |
| hit_valid | output | 1 | Result valid, one cycle after the strobe |
| hit | output | 1 | Address claimed |
| hit_win | output | 2 | Claiming window code |
| io_win_base | output | 32 | Decoded I/O base |
| io_win_limit | output | 32 | Decoded I/O limit |
| mem_win_base | output | 64 | Decoded memory base |
| mem_win_limit | output | 64 | Decoded memory limit |
| pf_win_base | output | 64 | Decoded prefetchable base |
| pf_win_limit | output | 64 | Decoded prefetchable limit |

## Verification
A single memory address can satisfy the prefetchable window, the memory window and the legacy display range in the same cycle. The bench provokes this in two ways. It programs the memory and prefetchable windows to cover the same region, and it programs a memory window from zero that covers 0xA0000. The reported code must then follow the priority order. An I/O request can also match the I/O window and a legacy display port at once. This is forced by placing the I/O window over 0x3C0, and the I/O code must win. The behavioural model computes each outcome from its own arithmetic and compares it every clock.

// File: rtl/bwd_pkg.sv
package bwd_pkg;
  localparam int ADDR_W       = 64;
  localparam int IO_ADDR_W    = 32;
  localparam int IO_GRAN_BITS = 12;
  localparam int MEM_GRAN_BITS = 20;
  localparam int VGA_PORT_W   = 16;

  localparam logic [VGA_PORT_W-1:0] VGA_MONO_LO  = 16'h03B0;
  localparam logic [VGA_PORT_W-1:0] VGA_MONO_HI  = 16'h03BB;
  localparam logic [VGA_PORT_W-1:0] VGA_COLOR_LO = 16'h03C0;
  localparam logic [VGA_PORT_W-1:0] VGA_COLOR_HI = 16'h03DF;
  localparam logic [ADDR_W-1:0]     VGA_FB_LO    = 64'h000A_0000;
  localparam logic [ADDR_W-1:0]     VGA_FB_HI    = 64'h000B_FFFF;

  typedef enum logic [1:0] {
    WIN_IO   = 2'd0,
    WIN_MEM  = 2'd1,
    WIN_PREF = 2'd2,
    WIN_VGA  = 2'd3
  } win_id_e;

  // I/O field: nibble 7:4 lands at 15:12, upper word only for 32-bit type
  function automatic logic [IO_ADDR_W-1:0] io_field(input logic [7:0] packed_b,
                                                    input logic [15:0] upper,
                                                    input logic fill);
    logic [IO_ADDR_W-1:0] v;
    v = {16'h0000, packed_b[7:4], 12'h000};
    if (packed_b[0]) v[31:16] = upper;
    if (fill) v[IO_GRAN_BITS-1:0] = '1;
    return v;
  endfunction

  // Memory field: word 15:4 lands at 31:20, upper dword only when wide
  function automatic logic [ADDR_W-1:0] mem_field(input logic [15:0] packed_w,
                                                  input logic [31:0] upper,
                                                  input logic wide,
                                                  input logic fill);
    logic [ADDR_W-1:0] v;
    v = {32'h0, packed_w[15:4], 20'h00000};
    if (wide) v[63:32] = upper;
    if (fill) v[MEM_GRAN_BITS-1:0] = '1;
    return v;
  endfunction

  function automatic logic in_range64(input logic [ADDR_W-1:0] a,
                                      input logic [ADDR_W-1:0] lo,
                                      input logic [ADDR_W-1:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction
endpackage

// File: rtl/bwd_io_window.sv
module bwd_io_window
  import bwd_pkg::*;
(
  input  logic [7:0]           base_b,
  input  logic [7:0]           limit_b,
  input  logic [15:0]          base_hi,
  input  logic [15:0]          limit_hi,
  input  logic                 en,
  input  logic [IO_ADDR_W-1:0] addr,
  output logic [IO_ADDR_W-1:0] win_base,
  output logic [IO_ADDR_W-1:0] win_limit,
  output logic                 empty,
  output logic                 match
);
  always_comb begin
    win_base  = io_field(base_b, base_hi, 1'b0);
    win_limit = io_field(limit_b, limit_hi, 1'b1);
    empty     = win_limit < win_base;
    match     = en && !empty && (addr >= win_base) && (addr <= win_limit);
  end
endmodule

// File: rtl/bwd_mem_window.sv
module bwd_mem_window
  import bwd_pkg::*;
#(
  parameter bit WIDE_OK = 1'b0
) (
  input  logic [15:0]       base_w,
  input  logic [15:0]       limit_w,
  input  logic [31:0]       base_hi,
  input  logic [31:0]       limit_hi,
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] win_base,
  output logic [ADDR_W-1:0] win_limit,
  output logic              empty,
  output logic              match
);
  logic base_wide, limit_wide;

  generate
    if (WIDE_OK) begin : g_wide
      assign base_wide  = base_w[0];
      assign limit_wide = limit_w[0];
    end else begin : g_narrow
      assign base_wide  = 1'b0;
      assign limit_wide = 1'b0;
    end
  endgenerate

  always_comb begin
    win_base  = mem_field(base_w, base_hi, base_wide, 1'b0);
    win_limit = mem_field(limit_w, limit_hi, limit_wide, 1'b1);
    empty     = win_limit < win_base;
    match     = en && !empty && in_range64(addr, win_base, win_limit);
  end
endmodule

// File: rtl/bwd_vga_match.sv
module bwd_vga_match
  import bwd_pkg::*;
(
  input  logic              vga_en,
  input  logic              io_en,
  input  logic              mem_en,
  input  logic              is_io,
  input  logic [ADDR_W-1:0] addr,
  output logic              match
);
  logic [VGA_PORT_W-1:0] port;
  logic io_hit, mem_hit;

  always_comb begin
    port    = addr[VGA_PORT_W-1:0];
    io_hit  = ((port >= VGA_MONO_LO) && (port <= VGA_MONO_HI)) ||
              ((port >= VGA_COLOR_LO) && (port <= VGA_COLOR_HI));
    mem_hit = in_range64(addr, VGA_FB_LO, VGA_FB_HI);
    match   = vga_en && (is_io ? (io_en && io_hit) : (mem_en && mem_hit));
  end
endmodule

// File: rtl/bridge_window_decoder.sv
module bridge_window_decoder
  import bwd_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_is_io,
  input  logic [63:0]          req_addr,
  input  logic [7:0]           cfg_io_base,
  input  logic [7:0]           cfg_io_limit,
  input  logic [15:0]          cfg_io_base_hi,
  input  logic [15:0]          cfg_io_limit_hi,
  input  logic [15:0]          cfg_mem_base,
  input  logic [15:0]          cfg_mem_limit,
  input  logic [15:0]          cfg_pf_base,
  input  logic [15:0]          cfg_pf_limit,
  input  logic [31:0]          cfg_pf_base_hi,
  input  logic [31:0]          cfg_pf_limit_hi,
  input  logic                 cfg_io_en,
  input  logic                 cfg_mem_en,
  input  logic                 cfg_vga_en,
  output logic                 hit_valid,
  output logic                 hit,
  output logic [1:0]           hit_win,
  output logic [31:0]          io_win_base,
  output logic [31:0]          io_win_limit,
  output logic [63:0]          mem_win_base,
  output logic [63:0]          mem_win_limit,
  output logic [63:0]          pf_win_base,
  output logic [63:0]          pf_win_limit
);
  // named internal events, visible to the bound checker
  logic    io_match, mem_match, pf_match, vga_hit;
  logic    io_empty, mem_empty, pf_empty;
  logic    sel_hit;
  win_id_e sel_win;
  win_id_e win_q;

  bwd_io_window u_io (
    .base_b   (cfg_io_base),
    .limit_b  (cfg_io_limit),
    .base_hi  (cfg_io_base_hi),
    .limit_hi (cfg_io_limit_hi),
    .en       (cfg_io_en),
    .addr     (req_addr[IO_ADDR_W-1:0]),
    .win_base (io_win_base),
    .win_limit(io_win_limit),
    .empty    (io_empty),
    .match    (io_match)
  );

  bwd_mem_window #(.WIDE_OK(1'b0)) u_mem (
    .base_w   (cfg_mem_base),
    .limit_w  (cfg_mem_limit),
    .base_hi  (32'h0),
    .limit_hi (32'h0),
    .en       (cfg_mem_en),
    .addr     (req_addr),
    .win_base (mem_win_base),
    .win_limit(mem_win_limit),
    .empty    (mem_empty),
    .match    (mem_match)
  );

  bwd_mem_window #(.WIDE_OK(1'b1)) u_pf (
    .base_w   (cfg_pf_base),
    .limit_w  (cfg_pf_limit),
    .base_hi  (cfg_pf_base_hi),
    .limit_hi (cfg_pf_limit_hi),
    .en       (cfg_mem_en),
    .addr     (req_addr),
    .win_base (pf_win_base),
    .win_limit(pf_win_limit),
    .empty    (pf_empty),
    .match    (pf_match)
  );

  bwd_vga_match u_vga (
    .vga_en (cfg_vga_en),
    .io_en  (cfg_io_en),
    .mem_en (cfg_mem_en),
    .is_io  (req_is_io),
    .addr   (req_addr),
    .match  (vga_hit)
  );

  // priority select: per space, window before legacy range
  always_comb begin
    sel_hit = 1'b0;
    sel_win = WIN_IO;
    if (req_is_io) begin
      if (io_match) begin
        sel_hit = 1'b1;
        sel_win = WIN_IO;
      end else if (vga_hit) begin
        sel_hit = 1'b1;
        sel_win = WIN_VGA;
      end
    end else begin
      if (pf_match) begin
        sel_hit = 1'b1;
        sel_win = WIN_PREF;
      end else if (mem_match) begin
        sel_hit = 1'b1;
        sel_win = WIN_MEM;
      end else if (vga_hit) begin
        sel_hit = 1'b1;
        sel_win = WIN_VGA;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_valid <= 1'b0;
      hit       <= 1'b0;
      win_q     <= WIN_IO;
    end else begin
      hit_valid <= req_valid;
      hit       <= req_valid && sel_hit;
      win_q     <= (req_valid && sel_hit) ? sel_win : WIN_IO;
    end
  end

  assign hit_win = win_q;
endmodule

// File: rtl/bridge_window_decoder_chk.sv
module bridge_window_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_is_io,
  input logic [15:0] cfg_pf_base,
  input logic        cfg_io_en,
  input logic        cfg_mem_en,
  input logic        hit_valid,
  input logic        hit,
  input logic [1:0]  hit_win,
  input logic [31:0] io_win_base,
  input logic [31:0] io_win_limit,
  input logic [63:0] mem_win_limit,
  input logic [63:0] pf_win_base,
  input logic [63:0] pf_win_limit,
  input logic        pf_match,
  input logic        mem_empty,
  input logic        pf_empty,
  input logic        vga_hit
);
  AST_RESULT_FOLLOWS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> hit_valid); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_valid |-> (!hit && hit_win == 2'd0)); // R11

  AST_MEM_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_is_io && !cfg_mem_en) |=> !hit); // R6

  AST_IO_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_is_io && !cfg_io_en) |=> !hit); // R6

  AST_EMPTY_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_is_io && mem_empty && pf_empty && !vga_hit) |=> !hit); // R7

  AST_IO_GRANULE: assert property (@(posedge clk) disable iff (!rst_n)
    (io_win_limit[11:0] == 12'hFFF) && (io_win_base[11:0] == 12'h000)); // R3

  AST_MEM_GRANULE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_win_limit[19:0] == 20'hFFFFF) && (pf_win_limit[19:0] == 20'hFFFFF)); // R4

  AST_PF_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_pf_base[0] |-> (pf_win_base[63:32] == 32'h0)); // R5

  AST_IO_SPACE_CODES: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_is_io) |=> !(hit && (hit_win == 2'd1 || hit_win == 2'd2))); // R9

  AST_PREF_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_is_io && pf_match) |=> (hit && hit_win == 2'd2)); // R9
endmodule

bind bridge_window_decoder bridge_window_decoder_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_is_io    (req_is_io),
  .cfg_pf_base  (cfg_pf_base),
  .cfg_io_en    (cfg_io_en),
  .cfg_mem_en   (cfg_mem_en),
  .hit_valid    (hit_valid),
  .hit          (hit),
  .hit_win      (hit_win),
  .io_win_base  (io_win_base),
  .io_win_limit (io_win_limit),
  .mem_win_limit(mem_win_limit),
  .pf_win_base  (pf_win_base),
  .pf_win_limit (pf_win_limit),
  .pf_match     (pf_match),
  .mem_empty    (mem_empty),
  .pf_empty     (pf_empty),
  .vga_hit      (vga_hit)
);

// File: tb/bridge_window_decoder_bench.sv
module bridge_window_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_is_io = 1'b0;
  logic [63:0] req_addr = '0;
  logic [7:0]  cfg_io_base = '0, cfg_io_limit = '0;
  logic [15:0] cfg_io_base_hi = '0, cfg_io_limit_hi = '0;
  logic [15:0] cfg_mem_base = '0, cfg_mem_limit = '0;
  logic [15:0] cfg_pf_base = '0, cfg_pf_limit = '0;
  logic [31:0] cfg_pf_base_hi = '0, cfg_pf_limit_hi = '0;
  logic        cfg_io_en = 1'b0, cfg_mem_en = 1'b0, cfg_vga_en = 1'b0;
  logic        hit_valid, hit;
  logic [1:0]  hit_win;
  logic [31:0] io_win_base, io_win_limit;
  logic [63:0] mem_win_base, mem_win_limit, pf_win_base, pf_win_limit;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  bridge_window_decoder u_bridge_window_decoder (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_io(req_is_io),
    .req_addr(req_addr), .cfg_io_base(cfg_io_base), .cfg_io_limit(cfg_io_limit),
    .cfg_io_base_hi(cfg_io_base_hi), .cfg_io_limit_hi(cfg_io_limit_hi),
    .cfg_mem_base(cfg_mem_base), .cfg_mem_limit(cfg_mem_limit),
    .cfg_pf_base(cfg_pf_base), .cfg_pf_limit(cfg_pf_limit),
    .cfg_pf_base_hi(cfg_pf_base_hi), .cfg_pf_limit_hi(cfg_pf_limit_hi),
    .cfg_io_en(cfg_io_en), .cfg_mem_en(cfg_mem_en), .cfg_vga_en(cfg_vga_en),
    .hit_valid(hit_valid), .hit(hit), .hit_win(hit_win),
    .io_win_base(io_win_base), .io_win_limit(io_win_limit),
    .mem_win_base(mem_win_base), .mem_win_limit(mem_win_limit),
    .pf_win_base(pf_win_base), .pf_win_limit(pf_win_limit)
  );

  // ---------------- behavioural reference (arithmetic form) ----------------
  function automatic longint unsigned m_io(input logic [7:0] b, input logic [15:0] h);
    longint unsigned v;
    v = longint'(b / 16) * 4096;
    if (b % 2 == 1) v = v + longint'(h) * 65536;
    return v;
  endfunction

  function automatic longint unsigned m_mem(input logic [15:0] w, input logic [31:0] h,
                                            input bit allow_wide);
    longint unsigned v;
    v = longint'(w / 16) * 1048576;
    if (allow_wide && (w % 2 == 1)) v = v + longint'(h) * 64'h1_0000_0000;
    return v;
  endfunction

  function automatic bit m_between(input longint unsigned a, input longint unsigned lo,
                                   input longint unsigned hi);
    return (lo <= a) && (a <= hi);
  endfunction

  // returns {hit, code}
  function automatic logic [2:0] m_decide();
    longint unsigned a, a32, a16;
    a   = req_addr;
    a32 = a % 64'h1_0000_0000;
    a16 = a % 65536;
    if (req_is_io) begin
      if (cfg_io_en && m_between(a32, m_io(cfg_io_base, cfg_io_base_hi),
                                 m_io(cfg_io_limit, cfg_io_limit_hi) + 4095))
        return 3'b1_00;
      if (cfg_io_en && cfg_vga_en &&
          (m_between(a16, 'h3B0, 'h3BB) || m_between(a16, 'h3C0, 'h3DF)))
        return 3'b1_11;
      return 3'b0_00;
    end
    if (!cfg_mem_en) return 3'b0_00;
    if (m_between(a, m_mem(cfg_pf_base, cfg_pf_base_hi, 1'b1),
                  m_mem(cfg_pf_limit, cfg_pf_limit_hi, 1'b1) + 64'hFFFFF))
      return 3'b1_10;
    if (m_between(a, m_mem(cfg_mem_base, 32'h0, 1'b0),
                  m_mem(cfg_mem_limit, 32'h0, 1'b0) + 64'hFFFFF))
      return 3'b1_01;
    if (cfg_vga_en && m_between(a, 'hA0000, 'hBFFFF)) return 3'b1_11;
    return 3'b0_00;
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_windows();
    check("R3", "io_base",   {32'h0, io_win_base},  m_io(cfg_io_base, cfg_io_base_hi));
    check("R3", "io_limit",  {32'h0, io_win_limit}, m_io(cfg_io_limit, cfg_io_limit_hi) + 4095);
    check("R4", "mem_base",  mem_win_base,  m_mem(cfg_mem_base, 32'h0, 1'b0));
    check("R4", "mem_limit", mem_win_limit, m_mem(cfg_mem_limit, 32'h0, 1'b0) + 64'hFFFFF);
    check("R5", "pf_base",   pf_win_base,   m_mem(cfg_pf_base, cfg_pf_base_hi, 1'b1));
    check("R5", "pf_limit",  pf_win_limit,  m_mem(cfg_pf_limit, cfg_pf_limit_hi, 1'b1) + 64'hFFFFF);
  endtask

  // inputs are driven just after a falling edge, compared at the next falling edge
  task automatic send(input bit io, input logic [63:0] addr, input string tag);
    logic [2:0] exp;
    req_valid = 1'b1;
    req_is_io = io;
    req_addr  = addr;
    exp = m_decide();
    @(negedge clk);
    check("R2", "hit_valid", {63'h0, hit_valid}, 64'd1);
    check(tag, "hit",     {63'h0, hit},     {63'h0, exp[2]});
    check(tag, "hit_win", {62'h0, hit_win}, {62'h0, exp[1:0]});
    check_windows();
    req_valid = 1'b0;
  endtask

  task automatic idle();
    req_valid = 1'b0;
    req_addr  = 64'hA0000;
    @(negedge clk);
    check("R2",  "hit_valid_idle", {63'h0, hit_valid}, 64'd0);
    check("R11", "hit_idle", {62'h0, hit_win, hit}, 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL R2 watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // reset state
    repeat (3) @(negedge clk);
    check("R1", "reset_outputs", {61'h0, hit_valid, hit, hit_win[0] | hit_win[1]}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "post_reset_outputs", {61'h0, hit_valid, hit, hit_win[0] | hit_win[1]}, 64'd0);

    // configuration A: all windows wide and enabled
    cfg_io_base = 8'h21;  cfg_io_base_hi  = 16'h0001;
    cfg_io_limit = 8'h31; cfg_io_limit_hi = 16'h0001;
    cfg_mem_base = 16'h1230; cfg_mem_limit = 16'h12F0;
    cfg_pf_base = 16'h4001;  cfg_pf_base_hi  = 32'h1;
    cfg_pf_limit = 16'h4FF1; cfg_pf_limit_hi = 32'h1;
    cfg_io_en = 1; cfg_mem_en = 1; cfg_vga_en = 1;
    send(1, 64'h0001_2000, "R3");
    send(1, 64'h0001_3FFF, "R3");
    send(1, 64'h0001_4000, "R3");
    send(1, 64'h0001_1FFF, "R3");
    send(1, 64'hFF00_0001_2345, "R10");
    idle();
    send(0, 64'h1230_0000, "R4");
    send(0, 64'h12FF_FFFF, "R4");
    send(0, 64'h1300_0000, "R4");
    send(0, 64'h1_4000_0000, "R5");
    send(0, 64'h1_4FFF_FFFF, "R5");
    send(0, 64'h4000_0000, "R10");
    send(0, 64'h2_4000_0000, "R10");
    idle();
    // legacy display ranges
    send(1, 64'h3B0, "R8"); send(1, 64'h3BB, "R8"); send(1, 64'h3BC, "R8");
    send(1, 64'h3C0, "R8"); send(1, 64'h3DF, "R8"); send(1, 64'h3E0, "R8");
    send(1, 64'h0100_03C5, "R8");
    send(0, 64'hA0000, "R8"); send(0, 64'hBFFFF, "R8"); send(0, 64'hC0000, "R8");
    send(0, 64'h9FFFF, "R8");
    cfg_vga_en = 0;
    send(1, 64'h3C0, "R8"); send(0, 64'hA0000, "R8");
    cfg_vga_en = 1;
    // narrow types ignore the upper words
    cfg_io_base = 8'h20; cfg_io_limit = 8'h30;
    send(1, 64'h2000, "R3"); send(1, 64'h0001_2000, "R3");
    cfg_pf_base = 16'h4000; cfg_pf_limit = 16'h4FF0;
    send(0, 64'h4000_0000, "R5"); send(0, 64'h1_4000_0000, "R5");
    // overlap: prefetchable over memory
    cfg_mem_base = 16'h4000; cfg_mem_limit = 16'h40F0;
    send(0, 64'h4000_0000, "R9"); send(0, 64'h40FF_FFFF, "R9");
    // overlap: memory over legacy display memory
    cfg_mem_base = 16'h0000; cfg_mem_limit = 16'h0000;
    send(0, 64'hA0000, "R9"); send(0, 64'hFFFFF, "R9");
    // overlap: I/O window over legacy display port
    cfg_io_base = 8'h00; cfg_io_limit = 8'h00;
    send(1, 64'h3C0, "R9"); send(1, 64'hA0000, "R9");
    idle();
    // enables
    cfg_mem_en = 0;
    send(0, 64'h4000_0000, "R6"); send(0, 64'hA0000, "R6");
    cfg_mem_en = 1; cfg_io_en = 0;
    send(1, 64'h3C0, "R6"); send(1, 64'h0500, "R6");
    cfg_io_en = 1;
    // empty windows
    cfg_vga_en = 0;
    cfg_mem_base = 16'h5000; cfg_mem_limit = 16'h4FF0;
    cfg_pf_base  = 16'h6000; cfg_pf_limit  = 16'h5000;
    send(0, 64'h5000_0000, "R7"); send(0, 64'h4FF0_0000, "R7");
    cfg_io_base = 8'h50; cfg_io_limit = 8'h40;
    send(1, 64'h4800, "R7"); send(1, 64'h5000, "R7");
    idle();
    // randomized sweep near window edges
    for (int i = 0; i < 400; i++) begin
      logic [63:0] a;
      if (i % 25 == 0) begin
        cfg_io_base = 8'($urandom); cfg_io_limit = 8'($urandom);
        cfg_io_base_hi = 16'($urandom_range(0, 2)); cfg_io_limit_hi = 16'($urandom_range(0, 2));
        cfg_mem_base = 16'($urandom_range(0, 16'h00F0)); cfg_mem_limit = 16'($urandom_range(0, 16'h00F0));
        cfg_pf_base = 16'($urandom_range(0, 16'h00FF)); cfg_pf_limit = 16'($urandom_range(0, 16'h00FF));
        cfg_pf_base_hi = 32'($urandom_range(0, 1)); cfg_pf_limit_hi = 32'($urandom_range(0, 1));
        cfg_io_en = 1'($urandom); cfg_mem_en = 1'($urandom); cfg_vga_en = 1'($urandom);
      end
      case ($urandom_range(0, 4))
        0: a = pf_win_base + 64'($urandom_range(0, 2)) - 64'd1;
        1: a = pf_win_limit + 64'($urandom_range(0, 1));
        2: a = mem_win_limit + 64'($urandom_range(0, 1));
        3: a = {32'h0, io_win_limit} + 64'($urandom_range(0, 1));
        default: a = 64'($urandom_range(32'h3A0, 32'h3E8)) | (64'($urandom_range(0, 1)) << 32);
      endcase
      if ($urandom_range(0, 3) == 0) idle();
      send(1'($urandom), a, "R9");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule